// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. It works in one system clock domain. A separate transmit clock input is synchronised and sampled, and every falling edge of that clock is one timing tick. Each serial bit lasts 1, 16 or 64 ticks, as the rate-factor select chooses. Frame shape is set at run time: 5 to 8 data bits, parity off, even or odd, and 1, 1.5 or 2 stop bits.

The host writes a character into a one-entry holding buffer. A frame starts on a tick only when the buffer is full, the transmit enable is high and the active-low clear-to-send input is low. When the frame starts, the character moves into the shifter and the buffer becomes free for the next write. Two status outputs tell the host that the buffer can take a write and that the whole transmitter is quiet.

Top module: `sertx_core`

## Requirements
- R1: After reset, and at all times while no frame is in progress, `txd_o` is 1. After reset `txrdy_o` and `txempty_o` are both 1.
- R2: A frame is one start bit (0), then the data bits from bit 0 upward, then the stop bits (1). The number of data bits is 5 + `len_sel_i` (0→5, 3→8). Data bits above that count are not sent.
- R3: When `par_en_i` is 1, one parity bit follows the last data bit. With `par_odd_i` = 0 it makes the count of ones in data plus parity even. With `par_odd_i` = 1 it makes that count odd.
- R4: `stop_sel_i` gives the stop length: 0 → 1 bit time, 1 → 1.5 bit times, 2 or 3 → 2 bit times. With the ×1 factor, the 1.5 setting gives 2 bit times.
- R5: One bit time is 1, 16 or 64 falling edges of `txc_i`, for `fac_sel_i` = 0, 1, or 2/3. `txd_o` changes only on the cycle after a falling edge of `txc_i` is detected.
- R6: A frame starts only when a character is held, `tx_en_i` is 1 and `cts_n_i` is 0. Otherwise `txd_o` stays 1 and the character stays held.
- R7: If `cts_n_i` rises during a frame, that frame still completes correctly. The next held character is not sent until `cts_n_i` is 0 again.
- R8: `txrdy_o` is 1 exactly while the holding buffer is empty. A write while `txrdy_o` is 0 is ignored and does not replace the held character.
- R9: `txempty_o` is 1 only when the buffer is empty and no frame is in progress. It is 0 during a frame, even after the buffer has been emptied.
- R10: The length, parity, stop and factor selects are captured when a frame starts. Changing them during a frame does not alter that frame.
- R11: If a character is held, enabled and cleared to send when the last stop tick of a frame ends, the next start bit follows at once, with no idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txc_i | input | 1 | Transmit clock; each falling edge is one timing tick |
| tx_en_i | input | 1 | Transmit enable |
| cts_n_i | input | 1 | Clear-to-send, active low |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 8 | Character to write |
| len_sel_i | input | 2 | Data length select, 5 + value bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel_i | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bit times |
| fac_sel_i | input | 2 | Ticks per bit: 0 = 1, 1 = 16, 2/3 = 64 |
| txd_o | output | 1 | Serial data line, idles high |
| txrdy_o | output | 1 | Holding buffer empty |
| txempty_o | output | 1 | Buffer empty and shifter idle |

## Verification
The assertions assume that `txc_i` is a slow clock, with each high and low phase much longer than the synchroniser delay, so that every falling edge gives exactly one tick. They also assume that the write strobe is a single-cycle pulse driven by a host that respects `txrdy_o`, except where a write to a full buffer is made on purpose. The bench drives `txc_i` as a regular clock with a period of four system cycles. It changes every input only on the inactive clock edge. It changes the selects in mid-frame only in the scenario that checks R10. Bit times and stop lengths are checked by measuring the distance in cycles between two back-to-back start bits, which does not depend on the synchroniser delay.

// File: rtl/sertx_pkg.sv
// Package: shared sizes, state type and timing helpers for the serial transmitter.
// Assumes character length select is LEN_W bits wide, giving lengths from
// CHAR_MAX/2+1 up to CHAR_MAX.
package sertx_pkg;

    localparam int LEN_W    = 2;
    localparam int IDX_W    = LEN_W + 1;
    localparam int CHAR_MAX = 1 << IDX_W;
    localparam int CNT_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } txst_t;

    // Ticks in one bit time for a rate-factor select value.
    function automatic logic [CNT_W-1:0] fac_ticks(input logic [1:0] fac);
        case (fac)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(16);
            default: return CNT_W'(64);
        endcase
    endfunction

    // Ticks in the stop period; 1.5 bits at factor x1 becomes 2 bits.
    function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] sel,
                                                    input logic [CNT_W-1:0] bit_t);
        case (sel)
            2'd0:    return bit_t;
            2'd1:    return (bit_t == CNT_W'(1)) ? (bit_t << 1) : (bit_t + (bit_t >> 1));
            default: return bit_t << 1;
        endcase
    endfunction

endpackage

// File: rtl/sertx_edge.sv
// Module: sertx_edge
// Synchronises the transmit clock into the system domain and gives a
// one-cycle tick for each falling edge. Assumes the transmit clock phases
// last longer than STAGES+1 system cycles.
module sertx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txc_i,
    output logic fall_o
);

    localparam int PW = STAGES + 1;

    logic [PW-1:0] pipe_q;

    // Shift the transmit clock through the synchroniser and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[PW-2:0], txc_i};
    end

    assign fall_o = pipe_q[PW-1] & ~pipe_q[PW-2];

    // R5: ticks are isolated single-cycle pulses
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o) else $error("tick lasted more than one cycle");

endmodule

// File: rtl/sertx_hold.sv
// Module: sertx_hold
// One-entry holding buffer between the host and the shifter. A write is
// taken only while empty; a take from the shifter frees the entry.
module sertx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);

    logic         full_q;
    logic [W-1:0] data_q;

    // Fill on a write to an empty entry, drain on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (wr_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= wr_data_i;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    // R8
    write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_i) |=> (data_q == $past(data_q)))
        else $error("held character replaced while full");

    // R8
    take_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> full_q) else $error("take from empty buffer");

endmodule

// File: rtl/sertx_frame.sv
// Module: sertx_frame
// Frame sequencer and shifter. It captures the frame settings and the held
// character when a frame starts, then sends start, data, parity and stop
// bits, timing each with a tick counter. Assumes tick_i is one-cycle pulses.
module sertx_frame
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                tx_en_i,
    input  logic                cts_n_i,
    input  logic                full_i,
    input  logic [CHAR_MAX-1:0] data_i,
    input  logic [LEN_W-1:0]    len_sel_i,
    input  logic                par_en_i,
    input  logic                par_odd_i,
    input  logic [1:0]          stop_sel_i,
    input  logic [1:0]          fac_sel_i,
    output logic                take_o,
    output logic                txd_o,
    output logic                idle_o
);

    txst_t                st_q;
    logic [CNT_W-1:0]     cnt_q, bit_lim_q, stop_lim_q;
    logic [IDX_W-1:0]     idx_q, last_q;
    logic [CHAR_MAX-1:0]  sh_q;
    logic                 par_en_q, par_bit_q, txd_q;

    logic [CNT_W-1:0]     cur_lim, fac_n, stop_n;
    logic [IDX_W-1:0]     last_n;
    logic [CHAR_MAX-1:0]  mdata;
    logic                 bit_end, start_ok, load, par_n;

    // Limits, next-frame settings and the start condition.
    always_comb begin
        cur_lim  = (st_q == ST_STOP) ? stop_lim_q : bit_lim_q;
        bit_end  = tick_i && (cnt_q == (cur_lim - 1'b1));
        start_ok = full_i && tx_en_i && !cts_n_i;
        load     = start_ok && tick_i &&
                   ((st_q == ST_IDLE) || ((st_q == ST_STOP) && bit_end));
        last_n   = {1'b1, len_sel_i};
        for (int i = 0; i < CHAR_MAX; i++)
            mdata[i] = data_i[i] & (IDX_W'(i) <= last_n);
        par_n    = par_odd_i ? ~^mdata : ^mdata;
        fac_n    = fac_ticks(fac_sel_i);
        stop_n   = stop_ticks(stop_sel_i, fac_n);
    end

    // Bit sequencing, shifting and tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            bit_lim_q  <= CNT_W'(1);
            stop_lim_q <= CNT_W'(1);
            idx_q      <= '0;
            last_q     <= '0;
            sh_q       <= '0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            txd_q      <= 1'b1;
        end else if (load) begin
            st_q       <= ST_START;
            cnt_q      <= '0;
            bit_lim_q  <= fac_n;
            stop_lim_q <= stop_n;
            last_q     <= last_n;
            sh_q       <= mdata;
            par_en_q   <= par_en_i;
            par_bit_q  <= par_n;
            txd_q      <= 1'b0;
        end else if (tick_i && (st_q != ST_IDLE)) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end) begin
                case (st_q)
                    ST_START: begin
                        st_q  <= ST_DATA;
                        idx_q <= '0;
                        txd_q <= sh_q[0];
                        sh_q  <= sh_q >> 1;
                    end
                    ST_DATA: begin
                        if (idx_q == last_q) begin
                            st_q  <= par_en_q ? ST_PAR : ST_STOP;
                            txd_q <= par_en_q ? par_bit_q : 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            txd_q <= sh_q[0];
                            sh_q  <= sh_q >> 1;
                        end
                    end
                    ST_PAR: begin
                        st_q  <= ST_STOP;
                        txd_q <= 1'b1;
                    end
                    default: begin
                        st_q  <= ST_IDLE;
                        txd_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign take_o = load;
    assign txd_o  = txd_q;
    assign idle_o = (st_q == ST_IDLE);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> txd_q) else $error("line low while idle");

    // R5
    change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd_q) |-> $past(tick_i)) else $error("line moved without a tick");

    // R6
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_q) && $past((st_q == ST_IDLE) || (st_q == ST_STOP))
        |-> $past(full_i && tx_en_i && !cts_n_i))
        else $error("frame started without enable, clear-to-send or data");

    // R10
    settings_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA) && $past(st_q == ST_DATA)
        |-> $stable(last_q) && $stable(bit_lim_q) && $stable(par_en_q))
        else $error("frame settings changed mid-frame");

endmodule

// File: rtl/sertx_core.sv
// Module: sertx_core (top)
// Programmable asynchronous serial transmitter: transmit-clock tick
// extraction, one-entry holding buffer and frame sequencer. Assumes all
// inputs except txc_i are synchronous to clk.
module sertx_core
    import sertx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txc_i,
    input  logic                tx_en_i,
    input  logic                cts_n_i,
    input  logic                wr_i,
    input  logic [CHAR_MAX-1:0] wr_data_i,
    input  logic [LEN_W-1:0]    len_sel_i,
    input  logic                par_en_i,
    input  logic                par_odd_i,
    input  logic [1:0]          stop_sel_i,
    input  logic [1:0]          fac_sel_i,
    output logic                txd_o,
    output logic                txrdy_o,
    output logic                txempty_o
);

    logic                tick, take, full, idle;
    logic [CHAR_MAX-1:0] held;

    sertx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .txc_i  (txc_i),
        .fall_o (tick)
    );

    sertx_hold #(.W(CHAR_MAX)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .take_i    (take),
        .full_o    (full),
        .data_o    (held)
    );

    sertx_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .tx_en_i    (tx_en_i),
        .cts_n_i    (cts_n_i),
        .full_i     (full),
        .data_i     (held),
        .len_sel_i  (len_sel_i),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .stop_sel_i (stop_sel_i),
        .fac_sel_i  (fac_sel_i),
        .take_o     (take),
        .txd_o      (txd_o),
        .idle_o     (idle)
    );

    assign txrdy_o   = ~full;
    assign txempty_o = ~full & idle;

    // R9
    empty_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txempty_o |-> (txd_o && txrdy_o)) else $error("empty flag during activity");

    // R8
    ready_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> txrdy_o) else $error("buffer not freed by frame start");

endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txc = 1'b0;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_sel = 2'd0;
    logic [1:0] fac_sel = 2'd0;
    logic       txd, txrdy, txempty;

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    int     tdiv = 0;

    sertx_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .txc_i      (txc),
        .tx_en_i    (tx_en),
        .cts_n_i    (cts_n),
        .wr_i       (wr),
        .wr_data_i  (wr_data),
        .len_sel_i  (len_sel),
        .par_en_i   (par_en),
        .par_odd_i  (par_odd),
        .stop_sel_i (stop_sel),
        .fac_sel_i  (fac_sel),
        .txd_o      (txd),
        .txrdy_o    (txrdy),
        .txempty_o  (txempty)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Transmit clock: period of four system cycles, driven on the inactive edge.
    always @(negedge clk) begin
        tdiv = tdiv + 1;
        if (tdiv == 2) begin
            tdiv = 0;
            txc = ~txc;
        end
    end

    task automatic chk(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input bit pe, input bit po,
                           input int stp, input int fac);
        len_sel  = 2'(len - 5);
        par_en   = pe;
        par_odd  = po;
        stop_sel = 2'(stp);
        fac_sel  = 2'(fac);
    endtask

    function automatic int bit_clks(input int fac);
        return (fac == 0) ? 4 : (fac == 1) ? 64 : 256;
    endfunction

    function automatic logic [7:0] mask_of(input int n);
        return 8'((1 << n) - 1);
    endfunction

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_start(input string rq, output longint t0);
        int k = 0;
        while (txd !== 1'b0 && k < 40000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 40000) chk({rq, " start timeout"}, 0, 1);
        t0 = cyc;
    endtask

    // Decode one frame at mid-bit points and check start and stop levels.
    task automatic read_frame(input int n, input bit pe, input int b, input string rq,
                              output logic [7:0] d, output logic p, output longint t0);
        d = '0;
        p = 1'b0;
        wait_start(rq, t0);
        wait_clk(b / 2);
        chk({rq, " start bit"}, txd, 0);
        for (int i = 0; i < n; i++) begin
            wait_clk(b);
            d[i] = txd;
        end
        if (pe) begin
            wait_clk(b);
            p = txd;
        end
        wait_clk(b);
        chk({rq, " stop bit"}, txd, 1);
    endtask

    task automatic hold_high(input int n, input string rq);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk({rq, " line held high"}, lows, 0);
    endtask

    task automatic write_when_ready(input logic [7:0] d);
        wait (txrdy == 1'b0);
        wait (txrdy == 1'b1);
        write_char(d);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 txd after reset", txd, 1);
        chk("R1 txrdy after reset", txrdy, 1);
        chk("R1 txempty after reset", txempty, 1);
        hold_high(40, "R1 idle");
    endtask

    // R2, R5: data order and length truncation
    task automatic t_format();
        logic [7:0] d;
        logic p;
        longint t0;
        tx_en = 1'b1;
        cts_n = 1'b0;
        set_cfg(8, 0, 0, 0, 0);
        write_char(8'hA5);
        read_frame(8, 0, bit_clks(0), "R2 len8", d, p, t0);
        chk("R2 len8 data", d, 8'hA5);
        set_cfg(5, 0, 0, 0, 1);
        write_char(8'hF6);
        read_frame(5, 0, bit_clks(1), "R2 len5", d, p, t0);
        chk("R2 len5 data", d, 8'hF6 & mask_of(5));
        wait_clk(200);
    endtask

    // R3: parity after the last data bit
    task automatic t_parity();
        logic [7:0] d;
        logic p;
        longint t0;
        set_cfg(7, 1, 0, 0, 1);
        write_char(8'hB5);
        read_frame(7, 1, bit_clks(1), "R3 even", d, p, t0);
        chk("R3 even data", d, 8'hB5 & mask_of(7));
        chk("R3 even parity", p, ^(8'hB5 & mask_of(7)));
        set_cfg(6, 1, 1, 0, 0);
        write_char(8'h07);
        read_frame(6, 1, bit_clks(0), "R3 odd", d, p, t0);
        chk("R3 odd data", d, 8'h07);
        chk("R3 odd parity", p, ~^(8'h07 & mask_of(6)));
        set_cfg(8, 1, 1, 0, 0);
        write_char(8'h81);
        read_frame(8, 1, bit_clks(0), "R3 odd8", d, p, t0);
        chk("R3 odd8 parity", p, 1);
        wait_clk(100);
    endtask

    // R4, R5, R11: start-to-start distance of back-to-back frames
    task automatic pair_gap(input int len, input bit pe, input int stp, input int fac,
                            input int exp_clks, input string rq);
        logic [7:0] d;
        logic p;
        longint t0, t1;
        set_cfg(len, pe, 0, stp, fac);
        write_char(8'h3C);
        fork
            write_when_ready(8'hC3);
        join_none
        read_frame(len, pe, bit_clks(fac), rq, d, p, t0);
        chk({rq, " first data"}, d, 8'h3C & mask_of(len));
        read_frame(len, pe, bit_clks(fac), rq, d, p, t1);
        chk({rq, " second data"}, d, 8'hC3 & mask_of(len));
        chk({rq, " start spacing"}, t1 - t0, exp_clks);
        wait_clk(4 * bit_clks(fac));
    endtask

    task automatic t_stop();
        pair_gap(8, 0, 0, 1, 9 * 64 + 64, "R4 stop1 R11");
        pair_gap(8, 0, 1, 1, 9 * 64 + 96, "R4 stop1.5");
        pair_gap(8, 0, 2, 1, 9 * 64 + 128, "R4 stop2");
        pair_gap(8, 0, 1, 0, 9 * 4 + 8, "R4 x1 stop1.5");
        pair_gap(5, 0, 0, 2, 7 * 256, "R5 x64");
        pair_gap(6, 1, 0, 0, 9 * 4, "R5 x1 parity");
    endtask

    // R6, R8: gating by enable and clear-to-send; write while full ignored
    task automatic t_gate();
        logic [7:0] d;
        logic p;
        longint t0;
        set_cfg(8, 0, 0, 0, 0);
        tx_en = 1'b0;
        cts_n = 1'b0;
        write_char(8'h5A);
        hold_high(120, "R6 disabled");
        chk("R8 txrdy low when held", txrdy, 0);
        chk("R6 character held", txempty, 0);
        write_char(8'hE7);
        tx_en = 1'b1;
        cts_n = 1'b1;
        hold_high(120, "R6 not clear");
        cts_n = 1'b0;
        read_frame(8, 0, bit_clks(0), "R8 held", d, p, t0);
        chk("R8 held data kept", d, 8'h5A);
        hold_high(200, "R8 no second frame");
        chk("R8 empty after one frame", txempty, 1);
    endtask

    // R7: clear-to-send removed mid-frame
    task automatic t_cts_mid();
        logic [7:0] d;
        logic p;
        longint t0;
        set_cfg(8, 0, 0, 0, 1);
        write_char(8'h96);
        fork
            begin
                write_when_ready(8'h69);
                wait_clk(200);
                cts_n = 1'b1;
            end
        join_none
        read_frame(8, 0, bit_clks(1), "R7 current", d, p, t0);
        chk("R7 current data", d, 8'h96);
        hold_high(1500, "R7 next held");
        chk("R7 next waits", txrdy, 0);
        cts_n = 1'b0;
        read_frame(8, 0, bit_clks(1), "R7 resumed", d, p, t0);
        chk("R7 resumed data", d, 8'h69);
        wait_clk(200);
    endtask

    // R10: settings changed during a frame
    task automatic t_cfg_change();
        logic [7:0] d;
        logic p;
        longint t0;
        set_cfg(8, 1, 0, 0, 1);
        write_char(8'h4D);
        fork
            begin
                wait_clk(150);
                set_cfg(5, 0, 1, 2, 0);
            end
        join_none
        read_frame(8, 1, bit_clks(1), "R10", d, p, t0);
        chk("R10 data", d, 8'h4D);
        chk("R10 parity", p, ^8'h4D);
        wait_clk(200);
    endtask

    // R9: empty flag through a frame
    task automatic t_empty();
        longint t0;
        set_cfg(8, 0, 0, 0, 1);
        write_char(8'h11);
        chk("R9 empty low when held", txempty, 0);
        wait_start("R9", t0);
        wait_clk(100);
        chk("R9 ready mid-frame", txrdy, 1);
        chk("R9 empty low mid-frame", txempty, 0);
        wait_clk(10 * 64 + 40);
        chk("R9 empty after frame", txempty, 1);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_format();
        t_parity();
        t_stop();
        t_gate();
        t_cts_mid();
        t_cfg_change();
        t_empty();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule